// File: doc/BRIEF.md
# Eight-Lane Fixed-Point Multiply-Accumulate Unit

This block is the multiply half of a vector arithmetic pipeline. Each 128-bit operand vector holds eight 16-bit lanes. Lane 0 is the most significant halfword (bits 127..112) and lane 7 the least (bits 15..0). For each lane, the unit multiplies a halfword of the source vector by a halfword of the target vector. Before that, the target vector passes through a broadcast selector steered by a 4-bit element code. The product is scaled according to the number format of the opcode. It either replaces or is added to a private 48-bit signed accumulator for that lane. The upper 32 accumulator bits (47..16), read as a signed number, are then clamped to 16 bits and written to the result vector.

An extract opcode does not change the accumulators. It copies one 16-bit slice of every accumulator lane into the result. A command is presented with `in_valid` for one cycle. The result and `out_valid` appear on the registered outputs on the next clock edge. Opcodes outside the supported set are dropped without any effect.

Top module: `vmac_unit`

## Requirements
- R1: After reset, `out_valid` is 0, `out_vd` is all zero and every accumulator lane is zero, so an extract returns zero.
- R2: Element codes 0 and 1 feed target lane i to lane i unchanged. Lane i occupies bits 127-16i down to 112-16i.
- R3: Element code 2 feeds target lanes 0,0,2,2,4,4,6,6 to lanes 0..7. Code 3 feeds lanes 1,1,3,3,5,5,7,7.
- R4: For element codes 4 to 7, with k = code-4, target lane k feeds lanes 0..3 and target lane k+4 feeds lanes 4..7.
- R5: For element codes 8 to 15, target lane (code-8) feeds all eight lanes.
- R6: Opcode 0x00 loads the accumulator with the signed product shifted left by one plus 0x8000. The result is accumulator bits 47..16, clamped to the signed range -32768..32767. For example, 0x8000 times 0x8000 gives 0x7FFF.
- R7: Opcode 0x01 behaves like 0x00 but clamps unsigned. A negative value gives 0x0000. A value above 32767 gives 0xFFFF. A value from 0 to 32767 passes unchanged.
- R8: Opcode 0x04 loads the accumulator with the zero-extended unsigned product in bits 31..0. Opcode 0x07 loads the signed product into bits 47..16. Both results are bits 47..16, clamped signed.
- R9: Opcodes 0x08, 0x09, 0x0C and 0x0F are the accumulating forms of 0x00, 0x01, 0x04 and 0x07. They add the sign-extended new term to the accumulator modulo 2^48 and clamp the new accumulator value. The fractional accumulating forms add no 0x8000 rounding constant.
- R10: Opcode 0x1D leaves the accumulators unchanged and writes a slice of each lane: bits 47..32 for element 8, bits 31..16 for element 9, bits 15..0 for element 10, and zero for any other element.
- R11: A valid command with any other opcode leaves `out_vd` and the accumulators unchanged, and `out_valid` stays 0.
- R12: `out_valid` is 1 for exactly the cycle after a valid supported command, and `out_vd` changes only on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command strobe, one cycle per command |
| in_op | input | 6 | Opcode |
| in_elem | input | 4 | Element code (broadcast pattern, or extract slice) |
| in_vs | input | 128 | Source vector, lane 0 in the top halfword |
| in_vt | input | 128 | Target vector, routed through the broadcast selector |
| out_valid | output | 1 | Result valid, one cycle after a supported command |
| out_vd | output | 128 | Registered result vector |

## Verification
The assertions assume that the command inputs carry known values from the first clock on. They also assume that `in_valid` alone decides whether the command is taken, with no stall or back-pressure. The single-lane broadcast check compares the selected lanes on every cycle, so it depends on `in_elem` and `in_vt` always being driven. The bench drives every input from time zero. It changes inputs only on falling edges and holds each command for exactly one cycle. The random stream mixes supported and unsupported opcodes with full-range operands and extreme halfwords such as 0x8000 and 0x7FFF.

// File: rtl/vmac_pkg.sv
package vmac_pkg;

  typedef enum logic [5:0] {
    OP_MUL_FS  = 6'h00,
    OP_MUL_FU  = 6'h01,
    OP_MUL_UU  = 6'h04,
    OP_MUL_SS  = 6'h07,
    OP_MAC_FS  = 6'h08,
    OP_MAC_FU  = 6'h09,
    OP_MAC_UU  = 6'h0C,
    OP_MAC_SS  = 6'h0F,
    OP_EXTRACT = 6'h1D
  } vop_e;

  typedef enum logic [1:0] {
    FMT_FRAC,
    FMT_UU,
    FMT_SS
  } fmt_e;

  typedef struct packed {
    logic known;
    logic mul;
    logic add;
    logic uclamp;
    logic ext;
    fmt_e fmt;
  } vctl_t;

endpackage

// File: rtl/vmac_decode.sv
module vmac_decode
  import vmac_pkg::*;
(
  input  logic [5:0] op,
  output vctl_t      ctl
);

  always_comb begin
    ctl = '{known: 1'b0, mul: 1'b0, add: 1'b0, uclamp: 1'b0, ext: 1'b0, fmt: FMT_FRAC};
    case (op)
      OP_MUL_FS, OP_MAC_FS: begin
        ctl.known = 1'b1; ctl.mul = 1'b1; ctl.fmt = FMT_FRAC;
      end
      OP_MUL_FU, OP_MAC_FU: begin
        ctl.known = 1'b1; ctl.mul = 1'b1; ctl.fmt = FMT_FRAC; ctl.uclamp = 1'b1;
      end
      OP_MUL_UU, OP_MAC_UU: begin
        ctl.known = 1'b1; ctl.mul = 1'b1; ctl.fmt = FMT_UU;
      end
      OP_MUL_SS, OP_MAC_SS: begin
        ctl.known = 1'b1; ctl.mul = 1'b1; ctl.fmt = FMT_SS;
      end
      OP_EXTRACT: begin
        ctl.known = 1'b1; ctl.ext = 1'b1;
      end
      default: ;
    endcase
    // bit 3 of the opcode marks the accumulating variant
    ctl.add = ctl.mul & op[3];
  end

endmodule

// File: rtl/vmac_bcast.sv
module vmac_bcast #(
  parameter int LANES = 8,   // the element code is defined for eight lanes
  parameter int LW    = 16
) (
  input  logic [3:0]          elem,
  input  logic [LANES*LW-1:0] vec_in,
  output logic [LANES*LW-1:0] vec_out
);

  localparam int VW = LANES * LW;
  localparam int IW = $clog2(LANES);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [IW-1:0] ME = IW'(i);
    logic [IW-1:0] src;

    always_comb begin
      if (elem[3])
        src = elem[IW-1:0];                       // single lane to all
      else if (elem[2])
        src = {ME[IW-1], elem[1:0]};              // one lane per half
      else if (elem[1])
        src = {ME[IW-1:1], elem[0]};              // one lane per pair
      else
        src = ME;                                 // straight through
    end

    assign vec_out[VW-1-LW*i -: LW] = vec_in[VW-1-LW*src -: LW];

    if (i > 0) begin : g_chk
      always_comb begin
        a_r5_single_lane: assert (!elem[3] ||
          vec_out[VW-1-LW*i -: LW] == vec_out[VW-1 -: LW]);
      end
    end
  end

endmodule

// File: rtl/vmac_lane.sv
module vmac_lane
  import vmac_pkg::*;
#(
  parameter int LW = 16,
  parameter int AW = 48
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  vctl_t         ctl,
  input  logic [3:0]    elem,
  input  logic [LW-1:0] a,
  input  logic [LW-1:0] b,
  output logic [LW-1:0] res_q
);

  localparam int PW = 2 * LW;     // product width
  localparam int HW = AW - LW;    // width of the clamped window
  localparam int XW = AW - PW;    // extension bits above a product

  logic [AW-1:0] acc_q;
  logic signed [PW-1:0] p_ss;
  logic [PW-1:0] p_uu;
  logic [AW-1:0] term, sum;
  logic [HW-1:0] hi;
  logic [LW-1:0] clamped, slice;
  logic          in_range;

  assign p_ss = $signed(a) * $signed(b);
  assign p_uu = {{LW{1'b0}}, a} * {{LW{1'b0}}, b};

  always_comb begin
    case (ctl.fmt)
      FMT_SS:  term = {p_ss, {XW{1'b0}}};
      FMT_UU:  term = {{XW{1'b0}}, p_uu};
      default: term = ({{XW{p_ss[PW-1]}}, p_ss} << 1)
                    + (ctl.add ? '0 : (AW'(1) << (LW - 1)));
    endcase
  end

  assign sum      = ctl.add ? acc_q + term : term;
  assign hi       = sum[AW-1:LW];
  assign in_range = (&hi[HW-1:LW-1]) | ~(|hi[HW-1:LW-1]);

  always_comb begin
    if (ctl.uclamp) begin
      if (hi[HW-1])                clamped = '0;
      else if (|hi[HW-2:LW-1])     clamped = '1;
      else                         clamped = hi[LW-1:0];
    end else begin
      if (in_range)                clamped = hi[LW-1:0];
      else if (hi[HW-1])           clamped = {1'b1, {(LW-1){1'b0}}};
      else                         clamped = {1'b0, {(LW-1){1'b1}}};
    end
  end

  always_comb begin
    case (elem)
      4'd8:    slice = acc_q[AW-1 -: LW];
      4'd9:    slice = acc_q[PW-1 -: LW];
      4'd10:   slice = acc_q[LW-1:0];
      default: slice = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      res_q <= '0;
    end else if (fire) begin
      if (ctl.ext) begin
        res_q <= slice;
      end else begin
        acc_q <= sum;
        res_q <= clamped;
      end
    end
  end

  a_r10_extract_keeps_acc: assert property (@(posedge clk) disable iff (rst)
    fire && ctl.ext |=> acc_q == $past(acc_q));

  a_r11_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !fire |=> acc_q == $past(acc_q) && res_q == $past(res_q));

  a_r7_unsigned_shape: assert property (@(posedge clk) disable iff (rst)
    fire && ctl.mul && ctl.uclamp |=> res_q == '0 || res_q == '1 || !res_q[LW-1]);

  a_r6_signed_sat: assert property (@(posedge clk) disable iff (rst)
    fire && ctl.mul && !ctl.uclamp && !in_range && !hi[HW-1]
    |=> res_q == {1'b0, {(LW-1){1'b1}}});

endmodule

// File: rtl/vmac_unit.sv
module vmac_unit
  import vmac_pkg::*;
#(
  parameter int LANES = 8,
  parameter int LW    = 16,
  parameter int AW    = 48
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [5:0]            in_op,
  input  logic [3:0]            in_elem,
  input  logic [LANES*LW-1:0]   in_vs,
  input  logic [LANES*LW-1:0]   in_vt,
  output logic                  out_valid,
  output logic [LANES*LW-1:0]   out_vd
);

  localparam int VW = LANES * LW;

  vctl_t         ctl;
  logic          fire;
  logic [VW-1:0] vt_sel;

  vmac_decode i_dec (.op(in_op), .ctl(ctl));

  vmac_bcast #(.LANES(LANES), .LW(LW)) i_bc (
    .elem(in_elem), .vec_in(in_vt), .vec_out(vt_sel));

  assign fire = in_valid & ctl.known;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    vmac_lane #(.LW(LW), .AW(AW)) i_lane (
      .clk  (clk),
      .rst  (rst),
      .fire (fire),
      .ctl  (ctl),
      .elem (in_elem),
      .a    (in_vs [VW-1-LW*i -: LW]),
      .b    (vt_sel[VW-1-LW*i -: LW]),
      .res_q(out_vd[VW-1-LW*i -: LW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= fire;
  end

  a_r12_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid && ctl.known |=> out_valid);

  a_r11_unknown_silent: assert property (@(posedge clk) disable iff (rst)
    in_valid && !ctl.known |=> !out_valid && $stable(out_vd));

  a_r12_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(out_vd));

endmodule

// File: tb/test_vmac_unit.sv
`timescale 1ns/1ps
module test_vmac_unit;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [5:0]   in_op = '0;
  logic [3:0]   in_elem = '0;
  logic [127:0] in_vs = '0;
  logic [127:0] in_vt = '0;
  logic         out_valid;
  logic [127:0] out_vd;

  int total = 0;
  int bad = 0;
  logic [47:0]  acc_m [8];
  logic [127:0] vd_m = '0;

  always #4 clk = ~clk;

  vmac_unit i_vmac_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_elem(in_elem),
    .in_vs(in_vs), .in_vt(in_vt), .out_valid(out_valid), .out_vd(out_vd));

  function automatic logic [15:0] ln(logic [127:0] v, int i);
    return v[127-16*i -: 16];
  endfunction

  function automatic int bidx(logic [3:0] e, int i);
    if (e < 2) return i;
    if (e < 4) return (i & 6) | (e & 1);
    if (e < 8) return (i & 4) | (e - 4);
    return e - 8;
  endfunction

  function automatic bit known(logic [5:0] op);
    case (op)
      6'h00, 6'h01, 6'h04, 6'h07, 6'h08, 6'h09, 6'h0C, 6'h0F, 6'h1D: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [5:0] op, logic [3:0] e, logic [127:0] vs,
                       logic [127:0] vt, string tag);
    logic [127:0] exp_vd = vd_m;
    bit exp_v = known(op);
    for (int i = 0; i < 8; i++) begin
      longint sa = longint'($signed(ln(vs, i)));
      longint sb = longint'($signed(ln(vt, bidx(e, i))));
      longint ua = longint'(ln(vs, i));
      longint ub = longint'(ln(vt, bidx(e, i)));
      bit     accf = op[3];
      longint t, h;
      logic [47:0] nw;
      if (!exp_v) continue;
      if (op == 6'h1D) begin
        exp_vd[127-16*i -: 16] = (e == 8) ? acc_m[i][47:32] :
                                 (e == 9) ? acc_m[i][31:16] :
                                 (e == 10) ? acc_m[i][15:0] : 16'h0;
        continue;
      end
      case (op & 6'h07)
        6'h04:   t = ua * ub;
        6'h07:   t = sa * sb * 65536;
        default: t = sa * sb * 2 + (accf ? 0 : 32768);
      endcase
      nw = accf ? acc_m[i] + 48'(t) : 48'(t);
      acc_m[i] = nw;
      h = longint'($signed(nw[47:16]));
      if ((op & 6'h07) == 6'h01)
        exp_vd[127-16*i -: 16] = (h < 0) ? 16'h0 : (h > 32767) ? 16'hFFFF : h[15:0];
      else
        exp_vd[127-16*i -: 16] = (h < -32768) ? 16'h8000 : (h > 32767) ? 16'h7FFF : h[15:0];
    end
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_elem = e; in_vs = vs; in_vt = vt;
    @(negedge clk);
    in_valid = 1'b0;
    vd_m = exp_vd;
    chk(out_valid == exp_v && out_vd == exp_vd, tag, {out_valid, out_vd[126:0]},
        {exp_v, exp_vd[126:0]});
    chk(out_vd == exp_vd, tag, out_vd, exp_vd);
  endtask

  function automatic logic [127:0] splat(logic [15:0] x);
    return {8{x}};
  endfunction

  localparam logic [127:0] SEQ = 128'h0001_0002_0003_0004_0005_0006_0007_0008;
  localparam logic [127:0] TVAL = 128'h0010_0020_0030_0040_0050_0060_0070_0080;

  initial begin
    for (int i = 0; i < 8; i++) acc_m[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(out_valid == 1'b0 && out_vd == '0, "R1", out_vd, '0);
    apply(6'h1D, 4'd9, '0, '0, "R1");
    apply(6'h1D, 4'd10, '0, '0, "R1");
    // R2 no broadcast
    apply(6'h07, 4'd0, SEQ, TVAL, "R2");
    apply(6'h07, 4'd1, SEQ, TVAL, "R2");
    // R3 pair broadcast
    apply(6'h07, 4'd2, SEQ, TVAL, "R3");
    apply(6'h07, 4'd3, SEQ, TVAL, "R3");
    // R4 half broadcast
    for (int e = 4; e < 8; e++) apply(6'h07, 4'(e), SEQ, TVAL, "R4");
    // R5 single lane
    for (int e = 8; e < 16; e++) apply(6'h07, 4'(e), SEQ, TVAL, "R5");
    // R6 fractional signed
    apply(6'h00, 4'd0, splat(16'h8000), splat(16'h8000), "R6");
    apply(6'h00, 4'd0, splat(16'h4000), splat(16'h4000), "R6");
    apply(6'h00, 4'd0, splat(16'h8000), splat(16'h7FFF), "R6");
    // R7 fractional unsigned
    apply(6'h01, 4'd0, splat(16'h8000), splat(16'h4000), "R7");
    apply(6'h01, 4'd0, splat(16'h8000), splat(16'h8000), "R7");
    apply(6'h01, 4'd0, splat(16'h2000), splat(16'h3000), "R7");
    // R8 integer forms
    apply(6'h04, 4'd0, splat(16'hFFFF), splat(16'hFFFF), "R8");
    apply(6'h04, 4'd0, splat(16'h0300), splat(16'h0100), "R8");
    apply(6'h07, 4'd0, splat(16'hFFFE), splat(16'h0003), "R8");
    // R9 accumulate and 48-bit wrap
    apply(6'h07, 4'd0, splat(16'h8000), splat(16'h8000), "R9");
    apply(6'h0F, 4'd0, splat(16'h8000), splat(16'h8000), "R9");
    apply(6'h1D, 4'd8, '0, '0, "R9");
    apply(6'h08, 4'd0, splat(16'h4000), splat(16'h4000), "R9");
    apply(6'h0C, 4'd0, SEQ, TVAL, "R9");
    apply(6'h09, 4'd0, splat(16'h8000), splat(16'h0001), "R9");
    // R10 extract slices
    apply(6'h00, 4'd0, SEQ, TVAL, "R10");
    apply(6'h1D, 4'd8, '0, '0, "R10");
    apply(6'h1D, 4'd9, '0, '0, "R10");
    apply(6'h1D, 4'd10, '0, '0, "R10");
    apply(6'h1D, 4'd3, '0, '0, "R10");
    apply(6'h1D, 4'd10, '0, '0, "R10");
    // R11 unsupported opcode ignored
    apply(6'h02, 4'd0, splat(16'h7FFF), splat(16'h7FFF), "R11");
    apply(6'h1D, 4'd10, '0, '0, "R11");
    apply(6'h10, 4'd8, splat(16'h1234), splat(16'h5678), "R11");
    apply(6'h1D, 4'd9, '0, '0, "R11");
    // R12 valid lasts one cycle
    @(negedge clk);
    chk(out_valid == 1'b0 && out_vd == vd_m, "R12", out_vd, vd_m);
    // random mix
    void'($urandom(32'd2024));
    for (int n = 0; n < 400; n++) begin
      logic [5:0] ops [10] = '{6'h00, 6'h01, 6'h04, 6'h07, 6'h08, 6'h09,
                               6'h0C, 6'h0F, 6'h1D, 6'h22};
      logic [127:0] va = {$urandom, $urandom, $urandom, $urandom};
      logic [127:0] vb = {$urandom, $urandom, $urandom, $urandom};
      if ($urandom_range(0, 4) == 0) va = splat($urandom_range(0, 1) ? 16'h8000 : 16'h7FFF);
      if ($urandom_range(0, 4) == 0) vb = splat($urandom_range(0, 1) ? 16'h8000 : 16'h7FFF);
      apply(ops[$urandom_range(0, 9)], 4'($urandom_range(0, 15)), va, vb, "R9_random");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog R12 act=%h exp=%h", 1'b0, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule